// File: doc/BRIEF.md
# Comparator Trip Majority-Vote Filter

This block conditions the single-bit result of an analog comparator before that result is allowed to trip a power stage. The comparator bit can be inverted. It then passes through a two-flop synchronizer and is sampled once per prescaled tick. Each sample enters a sliding history window, and a majority vote over that window produces a filtered level. A sticky latch holds any high filtered level until a dedicated clear strobe. A 2-bit source select routes one of four versions to the trip output: the raw bit, the synchronized bit, the filtered level or the latched level.

The prescale, window length and vote threshold are captured from the configuration pins only when the init strobe is pulsed. The same strobe preloads the whole history and the filtered level with the current synchronized bit. If the captured threshold is not a strict majority of the window, an error flag rises and the filter freezes. Clearing the enable forces the live outputs low at once, pauses sampling and leaves the latch untouched. A downstream event flag records trip activity until software writes an all-ones clear word.

There is no data stream here, so every pin is a plain level or strobe with no valid/ready handshake.

Top module: `cmp_trip_filter`

## Requirements
- R1: After reset, trip_out, status_out, latch_out, flag_out and cfg_err are all 0, and the captured configuration is prescale 0, window 1 sample, threshold 1.
- R2: The conditioned bit is cmp_raw XOR inv_en. Source select 0 shows it combinationally. The synchronized copy lags it by two clock edges.
- R3: A sample is taken on one clock edge out of every cfg_prescale+1 while enabled. The counter restarts at the init edge, so the first sample lands cfg_prescale+1 edges after it. The prescale takes effect only at filt_init.
- R4: Each sample pushes the synchronized bit into a window of the cfg_win+1 newest samples. The filtered level goes to 1 when at least cfg_thresh+1 of them are 1, goes to 0 when at least cfg_thresh+1 are 0, and otherwise holds. status_out is the filtered level gated by blk_en.
- R5: cfg_err is set at filt_init when 2*(cfg_thresh+1) <= cfg_win+1, and is cleared at a later filt_init that captures a valid pair. While cfg_err is 1, the filtered level does not change except by filt_init.
- R6: At the filt_init edge the whole history and the filtered level take the current synchronized bit. This applies whether or not the block is enabled.
- R7: out_sel encodes the trip source as 0 = raw conditioned bit, 1 = synchronized bit, 2 = filtered level, 3 = latched level. trip_out is 0 whenever blk_en is 0.
- R8: latch_out is set on any edge where blk_en and the filtered level are both 1. Otherwise latch_clr clears it, so a set in the same cycle wins over the clear.
- R9: With blk_en at 0, trip_out and status_out are 0 in the same cycle. Sampling and the prescale counter pause, and latch_out keeps its value unless latch_clr is pulsed.
- R10: flag_out is set on the edge after trip_out is 1. It is cleared only when flag_clr is all ones and trip_out is 0; set wins over clear. It cannot become set while blk_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 1 | Asynchronous comparator result |
| blk_en | input | 1 | Block enable |
| inv_en | input | 1 | Invert the comparator bit |
| cfg_prescale | input | PRE_W | Sample period minus one, in clocks |
| cfg_win | input | IDX_W | Window length minus one, in samples |
| cfg_thresh | input | IDX_W | Vote threshold minus one |
| out_sel | input | 2 | Trip source select |
| filt_init | input | 1 | Capture configuration and preload the filter |
| latch_clr | input | 1 | Clear the sticky latch |
| flag_clr | input | CLR_W | Flag clear word; all ones clears |
| trip_out | output | 1 | Selected trip signal |
| status_out | output | 1 | Live filtered level |
| latch_out | output | 1 | Sticky latched level |
| cfg_err | output | 1 | Captured threshold is not a strict majority |
| flag_out | output | 1 | Downstream trip event flag |

## Verification
Timing is counted from the clock edge after an input change:
- Source 0 answers in the same cycle.
- The synchronized bit moves two edges later.
- With prescale P, a filtered change lands on the edge that is a multiple of P+1 counted from the init edge.
- The latch and the event flag follow the filtered level and the trip output one edge later.

Stimulus is applied just after a rising edge. A behavioural model built on a sample queue advances on each rising edge and is compared with every output at the following falling edge. Directed checks sample immediately after the edge on which each result is due, and also one edge early to prove a result is not premature.

// File: rtl/ctf_pkg.sv
package ctf_pkg;

  typedef enum logic [1:0] {
    SRC_RAW   = 2'd0,
    SRC_SYNC  = 2'd1,
    SRC_FILT  = 2'd2,
    SRC_LATCH = 2'd3
  } trip_src_e;

endpackage

// File: rtl/ctf_sync.sv
module ctf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/ctf_tick.sv
module ctf_tick #(
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] limit,
  output logic             tick
);

  logic [PRE_W-1:0] cnt_q;

  assign tick = run && !restart && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (run)     cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
  end

  // Two ticks can never fall on adjacent edges unless the period is one clock.
  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (limit != '0)) |=> !tick);

endmodule

// File: rtl/ctf_vote.sv
module ctf_vote #(
  parameter  int WIN_MAX = 32,
  localparam int IDX_W   = $clog2(WIN_MAX),
  localparam int CNT_W   = $clog2(WIN_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             tick,
  input  logic             hold,
  input  logic             sample,
  input  logic [IDX_W-1:0] win_sel,
  input  logic [IDX_W-1:0] thr_sel,
  output logic             filt_q
);

  logic [WIN_MAX-1:0] hist_q;
  logic [WIN_MAX-1:0] hist_nx;
  logic [WIN_MAX-1:0] span_mask;
  logic [CNT_W-1:0]   ones;
  logic [CNT_W-1:0]   zeros;
  logic [CNT_W-1:0]   span;
  logic [CNT_W-1:0]   need;

  assign hist_nx = {hist_q[WIN_MAX-2:0], sample};
  assign span    = CNT_W'(win_sel) + 1'b1;
  assign need    = CNT_W'(thr_sel) + 1'b1;

  always_comb begin
    ones = '0;
    for (int i = 0; i < WIN_MAX; i++) begin
      span_mask[i] = (CNT_W'(i) < span);
      ones = ones + CNT_W'(hist_nx[i] & span_mask[i]);
    end
    zeros = span - ones;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      filt_q <= 1'b0;
    end else if (init) begin
      hist_q <= {WIN_MAX{sample}};
      filt_q <= sample;
    end else if (tick && !hold) begin
      hist_q <= hist_nx;
      if (ones >= need)       filt_q <= 1'b1;
      else if (zeros >= need) filt_q <= 1'b0;
    end
  end

  assert_init_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (filt_q == $past(sample)));

  assert_frozen_on_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !init) |=> $stable(filt_q));

endmodule

// File: rtl/cmp_trip_filter.sv
module cmp_trip_filter #(
  parameter  int PRE_W       = 10,
  parameter  int WIN_MAX     = 32,
  parameter  int CLR_W       = 16,
  parameter  int SYNC_STAGES = 2,
  localparam int IDX_W       = $clog2(WIN_MAX),
  localparam int CNT_W       = $clog2(WIN_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_raw,
  input  logic             blk_en,
  input  logic             inv_en,
  input  logic [PRE_W-1:0] cfg_prescale,
  input  logic [IDX_W-1:0] cfg_win,
  input  logic [IDX_W-1:0] cfg_thresh,
  input  logic [1:0]       out_sel,
  input  logic             filt_init,
  input  logic             latch_clr,
  input  logic [CLR_W-1:0] flag_clr,
  output logic             trip_out,
  output logic             status_out,
  output logic             latch_out,
  output logic             cfg_err,
  output logic             flag_out
);
  import ctf_pkg::*;

  logic             cmp_cond;
  logic             sync_bit;
  logic             tick;
  logic             filt_q;
  logic             latch_q;
  logic             flag_q;
  logic             err_q;
  logic             bad_cfg;
  logic [PRE_W-1:0] pre_sh;
  logic [IDX_W-1:0] win_sh;
  logic [IDX_W-1:0] thr_sh;
  logic [CNT_W:0]   vote_x2;
  logic [CNT_W:0]   span_n;
  trip_src_e        src;

  assign cmp_cond = cmp_raw ^ inv_en;

  ctf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (cmp_cond),
    .q     (sync_bit)
  );

  // Configuration shadow, loaded only on the init strobe.
  assign vote_x2 = ((CNT_W+1)'(cfg_thresh) << 1) + (CNT_W+1)'(2);
  assign span_n  = (CNT_W+1)'(cfg_win) + 1'b1;
  assign bad_cfg = (vote_x2 <= span_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_sh <= '0;
      win_sh <= '0;
      thr_sh <= '0;
      err_q  <= 1'b0;
    end else if (filt_init) begin
      pre_sh <= cfg_prescale;
      win_sh <= cfg_win;
      thr_sh <= cfg_thresh;
      err_q  <= bad_cfg;
    end
  end

  ctf_tick #(.PRE_W(PRE_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (blk_en),
    .restart (filt_init),
    .limit   (pre_sh),
    .tick    (tick)
  );

  ctf_vote #(.WIN_MAX(WIN_MAX)) u_vote (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (filt_init),
    .tick    (tick),
    .hold    (err_q),
    .sample  (sync_bit),
    .win_sel (win_sh),
    .thr_sel (thr_sh),
    .filt_q  (filt_q)
  );

  // Sticky latch: set beats clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  latch_q <= 1'b0;
    else if (blk_en && filt_q)   latch_q <= 1'b1;
    else if (latch_clr)          latch_q <= 1'b0;
  end

  assign src = trip_src_e'(out_sel);

  always_comb begin
    trip_out = 1'b0;
    if (blk_en) begin
      case (src)
        SRC_RAW:   trip_out = cmp_cond;
        SRC_SYNC:  trip_out = sync_bit;
        SRC_FILT:  trip_out = filt_q;
        SRC_LATCH: trip_out = latch_q;
        default:   trip_out = 1'b0;
      endcase
    end
  end

  // Downstream event flag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_q <= 1'b0;
    else if (trip_out)   flag_q <= 1'b1;
    else if (&flag_clr)  flag_q <= 1'b0;
  end

  assign status_out = blk_en & filt_q;
  assign latch_out  = latch_q;
  assign flag_out   = flag_q;
  assign cfg_err    = err_q;

  assert_latch_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_en && filt_q) |=> latch_q);

  assert_latch_keep_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_en && !latch_clr) |=> $stable(latch_q));

  assert_flag_quiet_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_en && !flag_q) |=> !flag_q);

  assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((&flag_clr) && !trip_out) |=> !flag_q);

endmodule

// File: tb/cmp_trip_filter_tb.sv
`timescale 1ns/1ps
module cmp_trip_filter_tb;

  localparam int PRE_W = 10;
  localparam int IDX_W = 5;
  localparam int CLR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmp_raw = 0, blk_en = 0, inv_en = 0, filt_init = 0, latch_clr = 0;
  logic [PRE_W-1:0] cfg_prescale = '0;
  logic [IDX_W-1:0] cfg_win = '0, cfg_thresh = '0;
  logic [1:0] out_sel = 2'd2;
  logic [CLR_W-1:0] flag_clr = '0;
  logic trip_out, status_out, latch_out, cfg_err, flag_out;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmp_trip_filter u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .blk_en(blk_en), .inv_en(inv_en),
    .cfg_prescale(cfg_prescale), .cfg_win(cfg_win), .cfg_thresh(cfg_thresh),
    .out_sel(out_sel), .filt_init(filt_init), .latch_clr(latch_clr), .flag_clr(flag_clr),
    .trip_out(trip_out), .status_out(status_out), .latch_out(latch_out),
    .cfg_err(cfg_err), .flag_out(flag_out)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit m_s1, m_s2, m_filt, m_latch, m_flag, m_err;
  int m_cnt, m_pre, m_win, m_thr;
  bit m_q[$] = '{1'b0};

  function automatic bit m_trip();
    if (!blk_en) return 1'b0;
    case (out_sel)
      2'd0: return cmp_raw ^ inv_en;
      2'd1: return m_s2;
      2'd2: return m_filt;
      default: return m_latch;
    endcase
  endfunction

  always @(posedge clk) begin : model
    bit nf, nl, nfl, tr;
    int ones;
    if (rst_n) begin
      tr = m_trip();
      nf = m_filt;
      if (filt_init) begin
        m_pre = int'(cfg_prescale);
        m_win = int'(cfg_win);
        m_thr = int'(cfg_thresh);
        m_err = (2 * (m_thr + 1) <= m_win + 1);
        m_q.delete();
        repeat (m_win + 1) m_q.push_front(m_s2);
        nf = m_s2;
        m_cnt = 0;
      end else if (blk_en) begin
        if (m_cnt == m_pre) begin
          m_cnt = 0;
          if (!m_err) begin
            m_q.push_front(m_s2);
            while (m_q.size() > m_win + 1) void'(m_q.pop_back());
            ones = 0;
            foreach (m_q[k]) ones += m_q[k];
            if (ones >= m_thr + 1) nf = 1'b1;
            else if (m_q.size() - ones >= m_thr + 1) nf = 1'b0;
          end
        end else m_cnt++;
      end
      nl = m_latch;
      if (blk_en && m_filt) nl = 1'b1;
      else if (latch_clr) nl = 1'b0;
      nfl = m_flag;
      if (tr) nfl = 1'b1;
      else if (&flag_clr) nfl = 1'b0;
      m_s2 = m_s1;
      m_s1 = cmp_raw ^ inv_en;
      m_filt = nf;
      m_latch = nl;
      m_flag = nfl;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R7 trip vs model", trip_out, m_trip());
      check("R4 status vs model", status_out, blk_en & m_filt);
      check("R8 latch vs model", latch_out, m_latch);
      check("R5 err vs model", cfg_err, m_err);
      check("R10 flag vs model", flag_out, m_flag);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_init(input int pre, input int win, input int thr);
    cfg_prescale = PRE_W'(pre);
    cfg_win = IDX_W'(win);
    cfg_thresh = IDX_W'(thr);
    filt_init = 1'b1;
    step(1);
    filt_init = 1'b0;
  endtask

  initial begin
    #250000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    blk_en = 1'b1;
    step(3);
    rst_n = 1'b1;
    #0.5;
    check("R1 trip reset", trip_out, 1'b0);
    check("R1 status reset", status_out, 1'b0);
    check("R1 latch reset", latch_out, 1'b0);
    check("R1 flag reset", flag_out, 1'b0);
    check("R1 err reset", cfg_err, 1'b0);
    step(2);

    // Sync latency then sample with no prescale
    do_init(0, 0, 0);
    cmp_raw = 1'b1;
    step(2);
    check("R2 sync not yet", status_out, 1'b0);
    step(1);
    check("R4 single sample vote", status_out, 1'b1);
    cmp_raw = 1'b0;
    step(6);

    // Prescale of 3: sample lands four edges after init
    do_init(3, 0, 0);
    cmp_raw = 1'b1;
    step(3);
    check("R3 no sample before tick", status_out, 1'b0);
    step(1);
    check("R3 sample on tick", status_out, 1'b1);
    cmp_raw = 1'b0;
    step(12);

    // 3-of-5 majority
    do_init(0, 4, 2);
    cmp_raw = 1'b1;
    step(2);
    cmp_raw = 1'b0;
    step(10);
    check("R4 glitch rejected", status_out, 1'b0);
    cmp_raw = 1'b1;
    step(10);
    check("R4 majority high", status_out, 1'b1);
    cmp_raw = 1'b0;
    step(3);
    check("R4 holds without majority", status_out, 1'b1);
    step(10);
    check("R4 majority low", status_out, 1'b0);
    cmp_raw = 1'b1;
    step(10);

    // Bad threshold: 2 of 5 is not a strict majority
    do_init(0, 4, 1);
    check("R5 err flagged", cfg_err, 1'b1);
    cmp_raw = 1'b0;
    step(10);
    check("R5 filter frozen", status_out, 1'b1);

    // Init preload
    do_init(0, 4, 2);
    check("R6 preload low", status_out, 1'b0);
    check("R5 err cleared", cfg_err, 1'b0);
    cmp_raw = 1'b1;
    step(3);
    do_init(0, 4, 2);
    check("R6 preload high", status_out, 1'b1);

    // Source select and invert
    out_sel = 2'd0;
    #0.5;
    check("R7 raw source", trip_out, 1'b1);
    inv_en = 1'b1;
    #0.5;
    check("R2 invert raw", trip_out, 1'b0);
    inv_en = 1'b0;
    out_sel = 2'd1;
    #0.5;
    check("R7 sync source", trip_out, 1'b1);
    cmp_raw = 1'b0;
    step(1);
    check("R2 sync lag 1", trip_out, 1'b1);
    step(1);
    check("R2 sync lag 2", trip_out, 1'b0);
    out_sel = 2'd3;
    #0.5;
    check("R7 latch source", trip_out, 1'b1);

    // Latch set beats clear, then clear
    out_sel = 2'd2;
    cmp_raw = 1'b1;
    step(10);
    latch_clr = 1'b1;
    step(1);
    latch_clr = 1'b0;
    check("R8 set wins", latch_out, 1'b1);
    cmp_raw = 1'b0;
    step(10);
    latch_clr = 1'b1;
    step(1);
    latch_clr = 1'b0;
    check("R8 cleared", latch_out, 1'b0);

    // Disable behaviour
    cmp_raw = 1'b1;
    step(10);
    flag_clr = '1;
    step(3);
    flag_clr = '0;
    blk_en = 1'b0;
    #0.5;
    check("R9 trip off", trip_out, 1'b0);
    check("R9 status off", status_out, 1'b0);
    check("R9 latch kept", latch_out, 1'b1);
    flag_clr = '1;
    step(1);
    flag_clr = '0;
    cmp_raw = 1'b0;
    step(10);
    check("R10 no set while off", flag_out, 1'b0);
    blk_en = 1'b1;
    #0.5;
    check("R9 sampling paused", status_out, 1'b1);

    // Flag
    step(1);
    check("R10 flag set", flag_out, 1'b1);
    step(5);
    flag_clr = 16'h7FFF;
    step(1);
    check("R10 partial clear ignored", flag_out, 1'b1);
    flag_clr = '1;
    step(1);
    flag_clr = '0;
    check("R10 flag cleared", flag_out, 1'b0);
    step(2);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule